// File: doc/BRIEF.md
# SDRAM Bank Command Timing Enforcer

This block sits between a memory request front end and the command pins of a four-bank SDRAM. It takes one request at a time: bank, row, column, and read or write. It turns the request into the ACTIVE, READ, WRITE and PRECHARGE commands needed to serve it. Each command is held back until every spacing rule, counted in clock cycles, is met.

The cycle counts come from nanosecond limits for one of two speed grades, chosen by a parameter at elaboration. Grade 0 runs at a 7.5 ns clock with CAS latency 3. Grade 1 runs at a 10 ns clock with CAS latency 2. A lower bound converts to cycles with a ceiling divide by the clock period. The upper bound on how long a row may stay open converts with a floor divide.

Each bank tracks:
- whether a row is open, and which one;
- how long that row has been open;
- its own activate, precharge and write-recovery windows.

A request to a row that is not open causes a precharge (if another row is open), then an activate, then the column command. The request is accepted only in the cycle the column command is chosen. Rows left idle are closed by the block before their maximum open time runs out. A read-data-valid strobe follows each READ by the CAS latency.

Top module: `sdram_cmd_timer`

## Requirements
- R1: Out of reset the command pins show deselect (cs_n, ras_n, cas_n, we_n all 1), rd_valid is 0 and req_ready is 0.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: ACTIVE is 0011, READ is 0101, WRITE is 0100, PRECHARGE is 0010, and idle is deselect. ACTIVE carries the row on addr[11:0]. READ and WRITE carry the column on addr[8:0] with addr[10]=0. PRECHARGE has addr[10]=0, so it closes only the bank on ba.
- R3: A READ or WRITE to a bank comes at least TRCD cycles after that bank's ACTIVE. TRCD is 3 for grade 0 (ceil of 20 ns / 7.5 ns) and is reached exactly when the request waits.
- R4: In one bank, PRECHARGE comes at least TRAS cycles after ACTIVE (6 for grade 0). ACTIVE comes at least TRP cycles after PRECHARGE (3). ACTIVE to ACTIVE is at least TRC cycles (9). Each gap is met exactly when it is the only thing holding the command back.
- R5: ACTIVE commands to any two banks are at least TRRD cycles apart (2 for grade 0).
- R6: PRECHARGE of a bank comes at least 2 cycles after the last WRITE to that bank, and exactly 2 when nothing else holds it back.
- R7: Requests that hit the open row issue their column commands on consecutive cycles.
- R8: For a request to a row other than the open one, the order is PRECHARGE, ACTIVE, then the column command. req_ready is high only in the cycle whose decision becomes that column command on the next cycle. Exactly one column command is issued per accepted request.
- R9: rd_valid is high exactly CL cycles after each READ on the pins (CL = 3 for grade 0), and at no other time.
- R10: A row is never open longer than RAS_MAX cycles (floor of 100 us / period; 13333 for grade 0). An idle open row is closed by the block no earlier than RAS_MAX-8 cycles after its ACTIVE. A later request to that bank starts with a new ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; fields held until accepted |
| req_ready | output | 1 | Request accepted in this cycle |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 9 | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select for the command |
| addr | output | 12 | Row, column or precharge address |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
The hardest state to reach from the ports is the forced close of an idle row. It needs a row held open for over thirteen thousand cycles with no request touching that bank. The bench opens a row with one read, then leaves the request port idle. It watches the pins until that bank's PRECHARGE appears, and checks the gap. It then sends a request to the same row and checks that an ACTIVE comes first. A bench-side monitor timestamps every command for each bank, and checks every spacing rule against its own cycle counts.

// File: rtl/sdram_tim_pkg.sv
package sdram_tim_pkg;

  typedef enum logic [2:0] {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE} cmd_e;

  localparam int ROW_DELAY_PS = 20000;        // activate to column
  localparam int PRE_DELAY_PS = 20000;        // precharge to activate
  localparam int ROW_LIFE_PS  = 100_000_000;  // maximum row open time
  localparam int WR_RECOV_CK  = 2;            // write data to precharge

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int floor_div(input int num, input int den);
    return num / den;
  endfunction

  function automatic int clk_ps(input int grade);
    return (grade == 0) ? 7500 : 10000;
  endfunction

  function automatic int cas_lat(input int grade);
    return (grade == 0) ? 3 : 2;
  endfunction

  function automatic int row_min_ps(input int grade);
    return (grade == 0) ? 45000 : 50000;
  endfunction

  function automatic int row_cycle_ps(input int grade);
    return (grade == 0) ? 67500 : 70000;
  endfunction

  function automatic int act_gap_ps(input int grade);
    return (grade == 0) ? 15000 : 16000;
  endfunction

endpackage

// File: rtl/sdram_gap_cnt.sv
module sdram_gap_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int ROW_W   = 12,
  parameter int TRCD    = 3,
  parameter int TRAS    = 6,
  parameter int TRC     = 9,
  parameter int TRP     = 3,
  parameter int TWR     = 2,
  parameter int RAS_MAX = 13333,
  parameter int GUARD   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic             rd_go,
  input  logic             wr_go,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             act_ok,
  output logic             must_close
);
  localparam int CW = $clog2(TRC + 1);
  localparam int AW = $clog2(RAS_MAX + 1);

  logic          rcd_done, ras_done, rc_done, rp_done, wr_done;
  logic [AW-1:0] age;

  sdram_gap_cnt #(.W(CW)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_go),
    .val(CW'(TRCD - 1)), .done(rcd_done));
  sdram_gap_cnt #(.W(CW)) u_ras (.clk(clk), .rst_n(rst_n), .load(act_go),
    .val(CW'(TRAS - 1)), .done(ras_done));
  sdram_gap_cnt #(.W(CW)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act_go),
    .val(CW'(TRC - 1)),  .done(rc_done));
  sdram_gap_cnt #(.W(CW)) u_rp  (.clk(clk), .rst_n(rst_n), .load(pre_go),
    .val(CW'(TRP - 1)),  .done(rp_done));
  sdram_gap_cnt #(.W(CW)) u_wr  (.clk(clk), .rst_n(rst_n), .load(wr_go),
    .val(CW'(TWR - 1)),  .done(wr_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
      age      <= '0;
    end else if (act_go) begin
      is_open  <= 1'b1;
      open_row <= act_row;
      age      <= '0;
    end else if (pre_go) begin
      is_open  <= 1'b0;
      age      <= '0;
    end else if (is_open && age != AW'(RAS_MAX)) begin
      age      <= age + 1'b1;
    end
  end

  assign must_close = is_open && (age >= AW'(RAS_MAX - GUARD));
  assign col_ok     = is_open && rcd_done && !must_close;
  assign pre_ok     = is_open && ras_done && wr_done;
  assign act_ok     = !is_open && rp_done && rc_done;

  AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || wr_go) |-> (is_open && rcd_done)); // R3
  AST_ACT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> (!is_open && rp_done && rc_done)); // R4
  AST_PRE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |-> (is_open && ras_done && wr_done)); // R6
  AST_ROW_LIFE: assert property (@(posedge clk) disable iff (!rst_n)
    is_open |-> (age < AW'(RAS_MAX))); // R10
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go,
  output logic rd_valid
);
  logic [DEPTH:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else        stage <= {stage[DEPTH-1:0], rd_go};
  end

  assign rd_valid = stage[DEPTH];
endmodule

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer
  import sdram_tim_pkg::*;
#(
  parameter int GRADE  = 0,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_valid
);
  localparam int PER     = clk_ps(GRADE);
  localparam int CL      = cas_lat(GRADE);
  localparam int TRCD    = ceil_div(ROW_DELAY_PS, PER);
  localparam int TRP     = ceil_div(PRE_DELAY_PS, PER);
  localparam int TRAS    = ceil_div(row_min_ps(GRADE), PER);
  localparam int TRC     = ceil_div(row_cycle_ps(GRADE), PER);
  localparam int TRRD    = ceil_div(act_gap_ps(GRADE), PER);
  localparam int RAS_MAX = floor_div(ROW_LIFE_PS, PER);
  localparam int NB      = 1 << BANK_W;
  localparam int GUARD   = 4;
  localparam int RW      = $clog2(TRRD + 1);

  cmd_e              dec_cmd;
  logic [BANK_W-1:0] dec_bank;
  logic [ADDR_W-1:0] dec_addr;
  logic [NB-1:0]     act_go, pre_go, rd_go, wr_go;
  logic [NB-1:0]     b_open, b_col_ok, b_pre_ok, b_act_ok, b_close;
  logic [ROW_W-1:0]  b_row [NB];
  logic              rrd_done;
  logic              act_issue;

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_bank
      logic sel;
      assign sel        = (dec_bank == BANK_W'(gb));
      assign act_go[gb] = sel && (dec_cmd == CMD_ACT);
      assign pre_go[gb] = sel && (dec_cmd == CMD_PRE);
      assign rd_go[gb]  = sel && (dec_cmd == CMD_RD);
      assign wr_go[gb]  = sel && (dec_cmd == CMD_WR);

      sdram_bank_timer #(
        .ROW_W(ROW_W), .TRCD(TRCD), .TRAS(TRAS), .TRC(TRC), .TRP(TRP),
        .TWR(WR_RECOV_CK), .RAS_MAX(RAS_MAX), .GUARD(GUARD)
      ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .act_go(act_go[gb]), .pre_go(pre_go[gb]),
        .rd_go(rd_go[gb]), .wr_go(wr_go[gb]),
        .act_row(req_row),
        .is_open(b_open[gb]), .open_row(b_row[gb]),
        .col_ok(b_col_ok[gb]), .pre_ok(b_pre_ok[gb]),
        .act_ok(b_act_ok[gb]), .must_close(b_close[gb])
      );
    end
  endgenerate

  assign act_issue = (dec_cmd == CMD_ACT);

  sdram_gap_cnt #(.W(RW)) u_rrd (.clk(clk), .rst_n(rst_n), .load(act_issue),
    .val(RW'(TRRD - 1)), .done(rrd_done));

  // Decision: forced close of an aging row first, then the request.
  always_comb begin
    logic              frc;
    logic [BANK_W-1:0] fbank;
    frc      = 1'b0;
    fbank    = '0;
    dec_cmd  = CMD_NOP;
    dec_bank = req_bank;
    dec_addr = '0;
    req_ready = 1'b0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (b_close[b] && b_pre_ok[b]) begin
        frc   = 1'b1;
        fbank = BANK_W'(b);
      end
    end
    if (frc) begin
      dec_cmd  = CMD_PRE;
      dec_bank = fbank;
    end else if (req_valid) begin
      if (b_open[req_bank]) begin
        if (b_row[req_bank] == req_row) begin
          if (b_col_ok[req_bank]) begin
            dec_cmd   = req_write ? CMD_WR : CMD_RD;
            dec_addr  = ADDR_W'(req_col);
            req_ready = 1'b1;
          end
        end else if (b_pre_ok[req_bank]) begin
          dec_cmd = CMD_PRE;
        end
      end else if (b_act_ok[req_bank] && rrd_done) begin
        dec_cmd  = CMD_ACT;
        dec_addr = ADDR_W'(req_row);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba   <= '0;
      addr <= '0;
    end else begin
      ba   <= dec_bank;
      addr <= dec_addr;
      unique case (dec_cmd)
        CMD_ACT: {cs_n, ras_n, cas_n, we_n} <= 4'b0011;
        CMD_RD:  {cs_n, ras_n, cas_n, we_n} <= 4'b0101;
        CMD_WR:  {cs_n, ras_n, cas_n, we_n} <= 4'b0100;
        CMD_PRE: {cs_n, ras_n, cas_n, we_n} <= 4'b0010;
        default: {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      endcase
    end
  end

  sdram_rd_pipe #(.DEPTH(CL)) u_rdp (
    .clk(clk), .rst_n(rst_n), .rd_go(|rd_go), .rd_valid(rd_valid));

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_go, pre_go, rd_go, wr_go})); // R2
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    act_issue |-> rrd_done); // R5
  AST_ACCEPT_COL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (!cs_n && ras_n && !cas_n && !addr[10])); // R8
endmodule

// File: tb/sdram_cmd_timer_tb.sv
module sdram_cmd_timer_tb;
  localparam int PER     = 7500;
  localparam int CL      = 3;
  localparam int TRCD    = (20000 + PER - 1) / PER;
  localparam int TRP     = (20000 + PER - 1) / PER;
  localparam int TRAS    = (45000 + PER - 1) / PER;
  localparam int TRC     = (67500 + PER - 1) / PER;
  localparam int TRRD    = (15000 + PER - 1) / PER;
  localparam int TWR     = 2;
  localparam int RAS_MAX = 100_000_000 / PER;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, rd_valid;
  logic [1:0] ba;
  logic [11:0] addr;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;
  int last_act[4], last_pre[4], last_wr[4], act_row[4];
  bit bopen[4];
  int last_act_any = -1000, last_rd = -1000, last_rd_addr = 0, last_rdv = -1000;
  int n_col = 0;
  bit exp_rdv[16];

  sdram_cmd_timer u_dut (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial for (int b = 0; b < 4; b++) begin
    last_act[b] = -1000; last_pre[b] = -1000; last_wr[b] = -1000; bopen[b] = 0;
  end

  // Monitor: timestamps every command and checks all spacing rules.
  always @(negedge clk) if (rst_n) begin
    int t, b;
    t = cyc; b = int'(ba);
    if (rd_valid || exp_rdv[t % 16])
      chk(rd_valid == exp_rdv[t % 16], "R9 rd_valid timing", int'(rd_valid), int'(exp_rdv[t % 16]));
    exp_rdv[t % 16] = 0;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011: begin
          chk(!bopen[b], "R4 ACT to closed bank", int'(bopen[b]), 0);
          chk(t - last_pre[b] >= TRP, "R4 PRE->ACT", t - last_pre[b], TRP);
          chk(t - last_act[b] >= TRC, "R4 ACT->ACT same bank", t - last_act[b], TRC);
          chk(t - last_act_any >= TRRD, "R5 ACT->ACT any bank", t - last_act_any, TRRD);
          bopen[b] = 1; last_act[b] = t; last_act_any = t; act_row[b] = int'(addr);
        end
        3'b101, 3'b100: begin
          chk(bopen[b], "R3 column to open bank", int'(bopen[b]), 1);
          chk(t - last_act[b] >= TRCD, "R3 ACT->column", t - last_act[b], TRCD);
          chk(addr[10] == 1'b0, "R2 column A10", int'(addr[10]), 0);
          n_col++;
          if (we_n) begin
            last_rd = t; last_rd_addr = int'(addr[8:0]);
            exp_rdv[(t + CL) % 16] = 1;
          end else last_wr[b] = t;
        end
        3'b010: begin
          chk(bopen[b], "R4 PRE open bank", int'(bopen[b]), 1);
          chk(t - last_act[b] >= TRAS, "R4 ACT->PRE", t - last_act[b], TRAS);
          chk(t - last_act[b] <= RAS_MAX, "R10 row life", t - last_act[b], RAS_MAX);
          chk(t - last_wr[b] >= TWR, "R6 WR->PRE", t - last_wr[b], TWR);
          chk(addr[10] == 1'b0, "R2 PRE single bank", int'(addr[10]), 0);
          bopen[b] = 0; last_pre[b] = t;
        end
        default: chk(0, "R2 illegal command", int'({ras_n, cas_n, we_n}), 3'b011);
      endcase
    end
  end

  task automatic do_req(input int b, input int row, input int col, input bit wr);
    bit got;
    req_valid = 1; req_bank = 2'(b); req_row = 12'(row); req_col = 9'(col); req_write = wr;
    do begin
      #1 got = req_ready;
      @(negedge clk);
    end while (!got);
    req_valid = 0;
    #2;
  endtask

  task automatic t_reset;
    #1;
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1 pins deselect", int'({cs_n, ras_n, cas_n, we_n}), 15);
    chk(rd_valid == 0, "R1 rd_valid", int'(rd_valid), 0);
    chk(req_ready == 0, "R1 req_ready", int'(req_ready), 0);
  endtask

  task automatic t_open_read;
    int r;
    do_req(0, 5, 7, 0);
    r = last_rd;
    chk(r - last_act[0] == TRCD, "R3 exact ACT->READ", r - last_act[0], TRCD);
    chk(act_row[0] == 5, "R2 ACT row", act_row[0], 5);
    chk(last_rd_addr == 7, "R2 READ column", last_rd_addr, 7);
    repeat (CL + 1) @(negedge clk);
    #2;
    chk(rd_valid == 0, "R9 single strobe", int'(rd_valid), 0);
  endtask

  task automatic t_hits;
    int t1, t2, t3;
    do_req(0, 5, 1, 0); t1 = last_rd;
    do_req(0, 5, 2, 0); t2 = last_rd;
    do_req(0, 5, 3, 0); t3 = last_rd;
    chk(t2 == t1 + 1, "R7 back-to-back 1", t2 - t1, 1);
    chk(t3 == t2 + 1, "R7 back-to-back 2", t3 - t2, 1);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_write_miss;
    int w, n0;
    do_req(0, 5, 9, 1); w = last_wr[0];
    n0 = n_col;
    do_req(0, 9, 3, 0);
    chk(last_pre[0] - w == TWR, "R6 exact WR->PRE", last_pre[0] - w, TWR);
    chk(last_act[0] - last_pre[0] == TRP, "R4 exact PRE->ACT", last_act[0] - last_pre[0], TRP);
    chk(last_rd - last_act[0] == TRCD, "R8 column after ACT", last_rd - last_act[0], TRCD);
    chk(act_row[0] == 9, "R8 new row opened", act_row[0], 9);
    chk(n_col - n0 == 1, "R8 one column per request", n_col - n0, 1);
  endtask

  task automatic t_fast_miss;
    int a1;
    do_req(1, 1, 0, 0); a1 = last_act[1];
    do_req(1, 2, 0, 0);
    chk(last_pre[1] - a1 == TRAS, "R4 exact ACT->PRE", last_pre[1] - a1, TRAS);
    chk(last_act[1] - a1 == TRC, "R4 exact ACT->ACT", last_act[1] - a1, TRC);
  endtask

  task automatic t_row_life;
    int a3, p3, n;
    do_req(3, 7, 1, 0); a3 = last_act[3];
    n = 0;
    while (last_pre[3] < a3 && n < 20000) begin @(negedge clk); n++; end
    #2;
    p3 = last_pre[3] - a3;
    chk(p3 <= RAS_MAX && p3 >= RAS_MAX - 8, "R10 forced close window", p3, RAS_MAX);
    do_req(3, 7, 2, 0);
    chk(last_act[3] > a3 + p3, "R10 reopen with ACT", last_act[3], a3 + p3 + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_open_read;
    t_hits;
    t_write_miss;
    t_fast_miss;
    t_row_life;
    repeat (8) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule